// File: doc/BRIEF.md
# Programmable Staircase Level Generator

The block produces a digital code that climbs in equal increments and falls back to zero once the next increment would pass a programmed ceiling, giving a staircase for a digital-to-analog converter. A free-running prescaler counts system clock cycles and issues a step tick once per programmed period. On each tick the step size is added to a level register. The ceiling check is a single comparison against a sum one bit wider than the level, so the block uses no divide or remainder logic.

With a 40 MHz system clock and the default period of 4000 cycles, the level moves at 10 kHz, once every 100 µs. Step size, ceiling and period are captured into shadow registers at reset and at every tick. A change made part-way through a step therefore takes effect only from the next tick. An enable input freezes the whole generator. A one-cycle strobe marks each level update.

Top module: `stair_gen`

## Requirements
- R1: While `rst` is high on a clock edge, `level` becomes 0, `step_stb` becomes 0 and the prescaler count restarts from zero. The configuration inputs are captured at that edge.
- R2: With `en` held high, a tick happens once every P clock edges, where P is the captured period. A period of 0 acts as 1. The first tick after reset comes on the P-th enabled edge.
- R3: At a tick where level + step does not exceed the captured maximum, `level` takes the value level + step. The sum is formed one bit wider than `level`, so a carry out of the level width counts as exceeding the maximum.
- R4: At a tick where level + step is strictly greater than the captured maximum, `level` becomes 0.
- R5: A sum exactly equal to the captured maximum is kept as the new level.
- R6: While `en` is low, `level` and the prescaler count hold their values and `step_stb` stays 0.
- R7: Step size, maximum and period are captured only at reset and at each tick. Changes at other times have no effect until the next tick.
- R8: `step_stb` is high for exactly the one cycle in which a new `level` value first appears. `level` never changes in a cycle where `step_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes level and prescaler |
| step_size | input | LVL_W | Increment added at each tick |
| max_level | input | LVL_W | Highest level kept before the return to zero |
| period | input | PER_W | Clock cycles between ticks |
| level | output | LVL_W | Current staircase code |
| step_stb | output | 1 | One-cycle pulse marking a level update |

## Verification
Two events can fall on the same edge: a level update at the terminal count, and the reload of the shadow configuration that sets the length and increment of the following step. The bench changes step size and period part-way through a step. It then checks that the tick still ends on the old period with the old increment, and that the next step uses the new values. A second case deasserts the enable exactly on the terminal-count cycle and checks that neither the update nor the reload takes place. A cycle-accurate arithmetic model runs beside the design over a sweep of ceilings, increments and periods, with the enable and configuration changes interleaved.

// File: rtl/stair_pkg.sv
package stair_pkg;

    localparam int unsigned SYS_CLK_HZ  = 40_000_000;
    localparam int unsigned STEP_HZ     = 10_000;
    localparam int unsigned DEF_PERIOD  = SYS_CLK_HZ / STEP_HZ;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_ZERO = 2'd2
    } lvl_act_e;

    function automatic lvl_act_e pick_action(input logic tick, input logic over);
        if (!tick)
            return ACT_HOLD;
        else if (over)
            return ACT_ZERO;
        else
            return ACT_STEP;
    endfunction

endpackage

// File: rtl/stair_cfg.sv
module stair_cfg #(
    parameter int unsigned LVL_W = 12,
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LVL_W-1:0] step_in,
    input  logic [LVL_W-1:0] max_in,
    input  logic [PER_W-1:0] period_in,
    output logic [LVL_W-1:0] step_q,
    output logic [LVL_W-1:0] max_q,
    output logic [PER_W-1:0] last_q
);

    logic [PER_W-1:0] last_next;

    always_comb begin
        if (period_in == '0)
            last_next = '0;
        else
            last_next = period_in - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            step_q <= step_in;
            max_q  <= max_in;
            last_q <= last_next;
        end
    end

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(step_q) && $stable(max_q) && $stable(last_q)));

endmodule

// File: rtl/stair_tick.sv
module stair_tick #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] last,
    output logic             tick
);

    logic [PER_W-1:0] cnt;

    assign tick = en && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    assert_count_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/stair_level.sv
module stair_level
    import stair_pkg::*;
#(
    parameter int unsigned LVL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [LVL_W-1:0] step,
    input  logic [LVL_W-1:0] max_lvl,
    output logic [LVL_W-1:0] level,
    output logic             stb
);

    logic [LVL_W:0] sum;
    logic           over;
    lvl_act_e       act;

    assign sum  = {1'b0, level} + {1'b0, step};
    assign over = sum > {1'b0, max_lvl};
    assign act  = pick_action(tick, over);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= tick;
            unique case (act)
                ACT_STEP: level <= sum[LVL_W-1:0];
                ACT_ZERO: level <= '0;
                default:  level <= level;
            endcase
        end
    end

    assert_level_within_max_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (level <= $past(max_lvl)));

    assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> stb);

endmodule

// File: rtl/stair_gen.sv
module stair_gen
    import stair_pkg::*;
#(
    parameter int unsigned LVL_W = 12,
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LVL_W-1:0] step_size,
    input  logic [LVL_W-1:0] max_level,
    input  logic [PER_W-1:0] period,
    output logic [LVL_W-1:0] level,
    output logic             step_stb
);

    logic             tick;
    logic [LVL_W-1:0] cfg_step;
    logic [LVL_W-1:0] cfg_max;
    logic [PER_W-1:0] cfg_last;

    stair_cfg #(.LVL_W(LVL_W), .PER_W(PER_W)) u_cfg (
        .clk(clk), .rst(rst), .load(tick),
        .step_in(step_size), .max_in(max_level), .period_in(period),
        .step_q(cfg_step), .max_q(cfg_max), .last_q(cfg_last)
    );

    stair_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst(rst), .en(en), .last(cfg_last), .tick(tick)
    );

    stair_level #(.LVL_W(LVL_W)) u_level (
        .clk(clk), .rst(rst), .tick(tick), .step(cfg_step), .max_lvl(cfg_max),
        .level(level), .stb(step_stb)
    );

    assert_level_only_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !step_stb |-> $stable(level));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        (step_stb && cfg_last != '0) |=> !step_stb);

    assert_no_strobe_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !step_stb);

endmodule

// File: tb/stair_gen_tb.sv
module stair_gen_tb;

    localparam int LW = 4;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [LW-1:0] step_size = '0;
    logic [LW-1:0] max_level = '0;
    logic [PW-1:0] period    = 4'd1;
    logic [LW-1:0] level;
    logic          step_stb;

    int tests = 0;
    int fails = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    stair_gen #(.LVL_W(LW), .PER_W(PW)) u_dut (
        .clk(clk), .rst(rst), .en(en), .step_size(step_size),
        .max_level(max_level), .period(period),
        .level(level), .step_stb(step_stb)
    );

    // arithmetic reference
    int m_lvl, m_cnt, m_step, m_max, m_last;
    bit m_stb;
    always @(posedge clk) begin
        if (rst) begin
            m_lvl  <= 0;
            m_cnt  <= 0;
            m_stb  <= 1'b0;
            m_step <= int'(step_size);
            m_max  <= int'(max_level);
            m_last <= (period == 0) ? 0 : int'(period) - 1;
        end else begin
            m_stb <= en && (m_cnt >= m_last);
            if (en && m_cnt >= m_last) begin
                m_cnt  <= 0;
                m_lvl  <= (m_lvl + m_step > m_max) ? 0 : m_lvl + m_step;
                m_step <= int'(step_size);
                m_max  <= int'(max_level);
                m_last <= (period == 0) ? 0 : int'(period) - 1;
            end else if (en) begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(int'(level) == m_lvl, "R3 model level", int'(level), m_lvl);
            chk(step_stb == m_stb, "R8 model strobe", int'(step_stb), int'(m_stb));
        end
    end

    task automatic cfg(input int s, input int m, input int p);
        step_size = LW'(s);
        max_level = LW'(m);
        period    = PW'(p);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_stb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!step_stb && n < 100);
    endtask

    int n;

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        cfg(5, 10, 2);
        en = 1'b1;
        do_reset();
        chk(level == 0, "R1 level after reset", int'(level), 0);
        chk(step_stb == 0, "R1 strobe after reset", int'(step_stb), 0);

        // R2/R3/R5/R4: step 5, max 10, period 2
        wait_stb(n);
        chk(n == 2, "R2 first tick distance", n, 2);
        chk(level == 5, "R3 first step", int'(level), 5);
        @(negedge clk);
        chk(step_stb == 0, "R8 strobe single cycle", int'(step_stb), 0);
        wait_stb(n);
        chk(n == 1, "R2 tick spacing", n + 1, 2);
        chk(level == 10, "R5 sum equal to max kept", int'(level), 10);
        wait_stb(n);
        chk(level == 0, "R4 exceed returns zero", int'(level), 0);

        // R3/R4 carry: step 9 max 15 period 1
        cfg(9, 15, 1);
        do_reset();
        wait_stb(n);
        chk(n == 1 && level == 9, "R2 period one first", int'(level), 9);
        wait_stb(n);
        chk(level == 0, "R3 carry treated as exceed", int'(level), 0);
        wait_stb(n);
        chk(level == 9, "R3 restart from zero", int'(level), 9);

        // R0 period acts as one
        cfg(2, 15, 0);
        do_reset();
        wait_stb(n);
        chk(n == 1 && level == 2, "R2 period zero acts as one", n, 1);

        // R6 enable hold
        cfg(3, 15, 3);
        do_reset();
        wait_stb(n);
        chk(level == 3, "R6 pre-hold level", int'(level), 3);
        en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(level == 3 && step_stb == 0, "R6 hold while disabled", int'(level), 3);
        end
        en = 1'b1;
        wait_stb(n);
        chk(n == 3, "R6 prescaler held", n, 3);
        chk(level == 6, "R6 resume step", int'(level), 6);

        // R6 disable on terminal cycle
        cfg(1, 15, 2);
        do_reset();
        @(negedge clk);
        en = 1'b0;
        cfg(4, 15, 5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(step_stb == 0 && level == 0, "R6 terminal count frozen", int'(level), 0);
        end
        en = 1'b1;
        wait_stb(n);
        chk(n == 1 && level == 1, "R7 held config unchanged", int'(level), 1);

        // R7 shadow registers
        cfg(2, 15, 4);
        do_reset();
        @(negedge clk);
        cfg(7, 15, 1);
        wait_stb(n);
        chk(n == 3, "R7 old period kept", n + 1, 4);
        chk(level == 2, "R7 old step kept", int'(level), 2);
        wait_stb(n);
        chk(n == 1, "R7 new period applied", n, 1);
        chk(level == 9, "R7 new step applied", int'(level), 9);

        // R1 prescaler restart
        cfg(1, 15, 4);
        do_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(level == 0, "R1 mid-run reset", int'(level), 0);
        wait_stb(n);
        chk(n == 4 && level == 1, "R1 prescaler restarted", n, 4);

        // sweep against arithmetic model
        model_on = 1'b1;
        foreach (sweep_max[mi]) begin
            for (int s = 0; s < 16; s++) begin
                for (int p = 1; p <= 5; p += 2) begin
                    cfg(s, sweep_max[mi], p);
                    do_reset();
                    for (int c = 0; c < 60; c++) begin
                        en = (c % 7) != 6;
                        if (c % 13 == 12) begin
                            step_size = step_size + 4'd3;
                            period    = PW'((int'(period) % 5) + 1);
                        end
                        @(negedge clk);
                    end
                end
            end
        end
        model_on = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    int sweep_max [4] = '{15, 10, 7, 0};

endmodule